// File: doc/BRIEF.md
# VLAN Membership Bitmap Range Updater

This block holds one VLAN membership bitmap per function. Each bitmap has 4096 bits, one for each VLAN ID, kept as 128 words of 32 bits in a small register memory. A caller presents a command word and a function index in the same cycle. The command word names a starting VLAN ID, a repeat length and a direction (set or clear). If the block accepts the command, it walks the bitmap one word at a time. For each word it reads the old value, builds a mask that covers only the part of the run falling in that word, and keeps only the bits that must actually flip. It writes the word back only when that mask is non-zero.

Each word takes two cycles, one to read and one to write. While the walk runs, `busy` is high, and a one-cycle `done` pulse marks the end. A bad command is answered at once with `done` and `param_err` together, and the table is not touched. A separate combinational read port lets any word be fetched while the block is idle.

Top module: `vlanbm_range_upd`

## Requirements
- R1: After reset, every word of every function reads zero and `busy`, `done` and `param_err` are low.
- R2: Command word layout: bits 11:0 hold the starting VLAN ID, bit 15 is the direction (0 = set, 1 = clear), and bits 27:16 hold the length L. The run covers the L+1 consecutive VLAN IDs beginning at the start. VLAN ID v maps to word v/32, bit v mod 32.
- R3: If any of bits 14:12 or 31:28 is non-zero, the command is rejected. `done` and `param_err` are both high in the cycle after acceptance, `busy` never rises, and the table is unchanged.
- R4: A function index above NUM_FUNC-1 (default 3) is rejected in the same way as R3.
- R5: After a valid command, `busy` is high from the cycle after acceptance for 2 cycles per word touched. `done` is then high for exactly one cycle, with `busy` low, and `param_err` stays low.
- R6: A command presented while `busy` is high is ignored and has no effect on the table.
- R7: A set turns on only the bits of the run, and a clear turns off only the bits of the run. Every other bit keeps its value, including run bits that were already in the target state.
- R8: A run may start and end in the middle of a word and may span many words. The number of words touched is (last VLAN)/32 − (start)/32 + 1.
- R9: A length of zero changes exactly one bit.
- R10: A run that would pass VLAN 4095 is cut off at word 127 of its own function. No other function's bitmap changes.
- R11: The read port returns word `rd_word` of function `rd_func` in the same cycle. A function index of NUM_FUNC or more reads zero.
- R12: The bitmaps of different functions are independent. A command changes only the function it names.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe; sampled only while idle |
| cmd_word | input | 32 | Start VLAN, direction flag, length and reserved fields |
| cmd_func | input | FIDX_W (3) | Function index whose bitmap is updated |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| param_err | output | 1 | High together with `done` when the command was rejected |
| rd_func | input | FIDX_W (3) | Read port function index |
| rd_word | input | 7 | Read port word index |
| rd_data | output | 32 | Addressed bitmap word |

## Verification
Wrong internal state shows up in two ways. A bad word pointer, starting bit or remaining count changes how long `busy` stays high, and this is visible in the first cycle where the 2-cycles-per-word timing diverges. A wrong edge mask or wrong direction leaves bits flipped or missing in the bitmap. These appear through the read port as soon as the walk finishes, so every word of every function is compared against the reference after each command. A leak into another function, or a command accepted while busy, appears the same way, as a word that differs from the reference.

// File: rtl/vlanbm_pkg.sv
package vlanbm_pkg;
  localparam int VID_W      = 12;
  localparam int WORD_W     = 32;
  localparam int BIT_W      = $clog2(WORD_W);
  localparam int WORDS      = (2 ** VID_W) / WORD_W;
  localparam int WIDX_W     = $clog2(WORDS);
  localparam int REM_W      = VID_W + 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } vlanbm_st_e;
endpackage

// File: rtl/vlanbm_cmd_check.sv
module vlanbm_cmd_check
  import vlanbm_pkg::*;
#(
  parameter int NUM_FUNC = 4,
  parameter int FIDX_W   = 3
) (
  input  logic [31:0]       cmd_word,
  input  logic [FIDX_W-1:0] func,
  output logic [VID_W-1:0]  start_vid,
  output logic [VID_W-1:0]  run_len,
  output logic              clr,
  output logic              bad
);
  localparam logic [FIDX_W-1:0] FUNC_MAX = FIDX_W'(NUM_FUNC - 1);

  always_comb begin
    start_vid = cmd_word[VID_W-1:0];
    clr       = cmd_word[15];
    run_len   = cmd_word[16 +: VID_W];
    bad       = (|cmd_word[14:VID_W]) | (|cmd_word[31:16+VID_W]) | (func > FUNC_MAX);
  end
endmodule

// File: rtl/vlanbm_mask_gen.sv
module vlanbm_mask_gen
  import vlanbm_pkg::*;
(
  input  logic signed [REM_W-1:0] remain,
  input  logic [BIT_W-1:0]        bit_pos,
  input  logic [WORD_W-1:0]       old_word,
  input  logic                    clr,
  output logic [WORD_W-1:0]       toggle
);
  logic [WORD_W-1:0] span;

  always_comb begin
    if (remain < REM_W'(WORD_W - 1))
      span = {WORD_W{1'b1}} >> (BIT_W'(WORD_W - 1) - remain[BIT_W-1:0]);
    else
      span = {WORD_W{1'b1}};
    span   = span << bit_pos;
    toggle = clr ? (span & old_word) : (span & ~old_word);
  end
endmodule

// File: rtl/vlanbm_table.sv
module vlanbm_table
  import vlanbm_pkg::*;
#(
  parameter int NUM_FUNC = 4,
  parameter int ADDR_W   = $clog2(NUM_FUNC * WORDS) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr_a,
  output logic [WORD_W-1:0] rdata_a,
  input  logic [ADDR_W-1:0] raddr_b,
  output logic [WORD_W-1:0] rdata_b
);
  localparam int DEPTH = NUM_FUNC * WORDS;

  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we && (int'(waddr) < DEPTH)) begin
      mem_q[waddr] <= wdata;
    end
  end

  always_comb begin
    rdata_a = (int'(raddr_a) < DEPTH) ? mem_q[raddr_a] : '0;
    rdata_b = (int'(raddr_b) < DEPTH) ? mem_q[raddr_b] : '0;
  end
endmodule

// File: rtl/vlanbm_range_upd.sv
module vlanbm_range_upd
  import vlanbm_pkg::*;
#(
  parameter int NUM_FUNC = 4,
  parameter int FIDX_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [31:0]       cmd_word,
  input  logic [FIDX_W-1:0] cmd_func,
  output logic              busy,
  output logic              done,
  output logic              param_err,
  input  logic [FIDX_W-1:0] rd_func,
  input  logic [WIDX_W-1:0] rd_word,
  output logic [WORD_W-1:0] rd_data
);
  localparam int ADDR_W = FIDX_W + WIDX_W;
  localparam logic [WIDX_W-1:0] LAST_WORD = WIDX_W'(WORDS - 1);

  vlanbm_st_e               st_q, st_n;
  logic [FIDX_W-1:0]        func_q, func_n;
  logic [WIDX_W-1:0]        word_q, word_n;
  logic [BIT_W-1:0]         bit_q, bit_n;
  logic signed [REM_W-1:0]  rem_q, rem_n, rem_after, step;
  logic                     clr_q, clr_n;
  logic [WORD_W-1:0]        old_q, old_n;
  logic                     done_q, done_n, err_q, err_n;
  logic                     ctx_en, we;

  logic [VID_W-1:0]  dec_vid, dec_len;
  logic              dec_clr, dec_bad;
  logic [WORD_W-1:0] toggle, rdata_a, rdata_b;
  logic [ADDR_W-1:0] walk_addr, rd_addr;

  vlanbm_cmd_check #(.NUM_FUNC(NUM_FUNC), .FIDX_W(FIDX_W)) i_check (
    .cmd_word (cmd_word),
    .func     (cmd_func),
    .start_vid(dec_vid),
    .run_len  (dec_len),
    .clr      (dec_clr),
    .bad      (dec_bad)
  );

  vlanbm_mask_gen i_mask (
    .remain  (rem_q),
    .bit_pos (bit_q),
    .old_word(old_q),
    .clr     (clr_q),
    .toggle  (toggle)
  );

  assign walk_addr = {func_q, word_q};
  assign rd_addr   = {rd_func, rd_word};

  vlanbm_table #(.NUM_FUNC(NUM_FUNC), .ADDR_W(ADDR_W)) i_table (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (we),
    .waddr  (walk_addr),
    .wdata  (old_q ^ toggle),
    .raddr_a(walk_addr),
    .rdata_a(rdata_a),
    .raddr_b(rd_addr),
    .rdata_b(rdata_b)
  );

  assign rd_data = (int'(rd_func) < NUM_FUNC) ? rdata_b : '0;

  // next-state logic
  always_comb begin
    st_n      = st_q;
    func_n    = func_q;
    word_n    = word_q;
    bit_n     = bit_q;
    rem_n     = rem_q;
    clr_n     = clr_q;
    old_n     = old_q;
    done_n    = 1'b0;
    err_n     = 1'b0;
    ctx_en    = 1'b0;
    we        = 1'b0;
    step      = REM_W'(WORD_W) - $signed({{(REM_W-BIT_W){1'b0}}, bit_q});
    rem_after = rem_q - step;
    unique case (st_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          if (dec_bad) begin
            done_n = 1'b1;
            err_n  = 1'b1;
          end else begin
            ctx_en = 1'b1;
            st_n   = ST_READ;
            func_n = cmd_func;
            word_n = dec_vid[VID_W-1:BIT_W];
            bit_n  = dec_vid[BIT_W-1:0];
            rem_n  = $signed({2'b00, dec_len});
            clr_n  = dec_clr;
          end
        end
      end
      ST_READ: begin
        ctx_en = 1'b1;
        old_n  = rdata_a;
        st_n   = ST_WRITE;
      end
      ST_WRITE: begin
        ctx_en = 1'b1;
        we     = |toggle;
        if (rem_after[REM_W-1] || (word_q == LAST_WORD)) begin
          st_n   = ST_IDLE;
          done_n = 1'b1;
        end else begin
          st_n   = ST_READ;
          word_n = word_q + 1'b1;
          bit_n  = '0;
          rem_n  = rem_after;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      func_q <= '0;
      word_q <= '0;
      bit_q  <= '0;
      rem_q  <= '0;
      clr_q  <= 1'b0;
      old_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      done_q <= done_n;
      err_q  <= err_n;
      if (ctx_en) begin
        func_q <= func_n;
        word_q <= word_n;
        bit_q  <= bit_n;
        rem_q  <= rem_n;
        clr_q  <= clr_n;
        old_q  <= old_n;
      end
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign done      = done_q;
  assign param_err = err_q;

  // R5
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R5
  busy_from_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid));
  // R3
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    param_err |-> done);
  // R6
  hold_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) |=> ($stable(func_q) && $stable(clr_q)));
  // R8
  word_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WRITE) |=> ((st_q == ST_IDLE) || (word_q == WIDX_W'($past(word_q) + 1'b1))));
  // R8
  rem_nonneg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WRITE) |-> !rem_q[REM_W-1]);
endmodule

// File: tb/test_vlanbm_range_upd.sv
module test_vlanbm_range_upd;
  localparam int NF = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [31:0] cmd_word;
  logic [2:0]  cmd_func;
  logic        busy, done, param_err;
  logic [2:0]  rd_func;
  logic [6:0]  rd_word;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;
  logic [31:0] mdl [NF][128];

  always #5 clk = ~clk;

  vlanbm_range_upd i_vlanbm_range_upd (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .cmd_func(cmd_func), .busy(busy), .done(done), .param_err(param_err),
    .rd_func(rd_func), .rd_word(rd_word), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int vid, input int len, input bit clr);
    return (32'(len) << 16) | (32'(clr) << 15) | 32'(vid);
  endfunction

  task automatic compare_table(input string rq);
    int bad_cnt = 0;
    logic [31:0] first_act = 0, first_exp = 0;
    for (int f = 0; f < NF; f++) begin
      for (int w = 0; w < 128; w++) begin
        rd_func = 3'(f);
        rd_word = 7'(w);
        #1;
        if (rd_data !== mdl[f][w]) begin
          if (bad_cnt == 0) begin
            first_act = rd_data;
            first_exp = mdl[f][w];
          end
          bad_cnt++;
        end
      end
    end
    chk(bad_cnt == 0, rq, first_act, first_exp);
  endtask

  task automatic run_cmd(input logic [31:0] cw, input logic [2:0] fn, input bit inject, input string rq);
    bit bad;
    int vid, len, last, n, total;
    bad  = (cw[14:12] != 0) || (cw[31:28] != 0) || (fn > 3'(NF - 1));
    vid  = int'(cw[11:0]);
    len  = int'(cw[27:16]);
    last = vid + len;
    if (last > 4095) last = 4095;
    n = last / 32 - vid / 32 + 1;
    if (!bad) begin
      for (int v = vid; v <= last; v++)
        mdl[fn][v / 32][v % 32] = ~cw[15];
    end
    total = bad ? 1 : 2 * n + 1;
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_word  = cw;
    cmd_func  = fn;
    @(negedge clk);
    cmd_valid = inject;
    cmd_word  = mk(0, 4095, 1'b0);
    cmd_func  = 3'd0;
    for (int k = 1; k <= total + 1; k++) begin
      chk(busy == (!bad && k <= 2 * n), {rq, " busy"}, busy, !bad && k <= 2 * n);
      chk(done == (k == total), {rq, " done"}, done, k == total);
      chk(param_err == (bad && k == 1), {rq, " param_err"}, param_err, bad && k == 1);
      if (k == 3) cmd_valid = 1'b0;
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    compare_table({rq, " table"});
  endtask

  initial begin
    #(200_000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int f = 0; f < NF; f++)
      for (int w = 0; w < 128; w++) mdl[f][w] = '0;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_word = '0; cmd_func = '0;
    rd_func = '0; rd_word = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy, "R1 busy", busy, 0);
    chk(!done, "R1 done", done, 0);
    chk(!param_err, "R1 param_err", param_err, 0);
    compare_table("R1 reset table");

    // R9 length zero, single bit
    run_cmd(mk(5, 0, 1'b0), 3'd0, 1'b0, "R9 single bit");
    // R8 run crossing a word edge mid-word
    run_cmd(mk(30, 5, 1'b0), 3'd1, 1'b0, "R8 cross edge");
    // R2 R8 whole bitmap set, R6 command injected while busy
    run_cmd(mk(0, 4095, 1'b0), 3'd2, 1'b1, "R6 R2 full set ignore busy");
    // R7 clear inside a full bitmap
    run_cmd(mk(40, 70, 1'b1), 3'd2, 1'b0, "R7 clear run");
    // R7 set over partly set bits
    run_cmd(mk(3, 40, 1'b0), 3'd1, 1'b0, "R7 set overlap");
    // R7 clear of already clear bits
    run_cmd(mk(200, 10, 1'b1), 3'd0, 1'b0, "R7 clear noop");
    // R10 clip at last word, R12 neighbour untouched
    run_cmd(mk(4000, 500, 1'b0), 3'd0, 1'b0, "R10 R12 clip");
    // R9 top bit
    run_cmd(mk(4095, 0, 1'b0), 3'd3, 1'b0, "R9 top bit");
    // R3 reserved bits
    run_cmd(32'h0000_1005, 3'd3, 1'b0, "R3 reserved vid");
    run_cmd(32'h1000_0005, 3'd3, 1'b0, "R3 reserved len");
    // R4 bad function index
    run_cmd(mk(7, 3, 1'b0), 3'd4, 1'b0, "R4 func range");
    // R8 run ending exactly on a word boundary
    run_cmd(mk(32, 63, 1'b0), 3'd3, 1'b0, "R8 aligned");
    // R11 out-of-range read function
    rd_func = 3'd5; rd_word = 7'd0; #1;
    chk(rd_data == 32'd0, "R11 read range", rd_data, 0);
    rd_func = 3'd2; rd_word = 7'd127; #1;
    chk(rd_data == mdl[2][127], "R11 read word", rd_data, mdl[2][127]);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule